// File: doc/BRIEF.md
# Sub-Word Write Merge Bridge

This block sits between a processor-side request port and a memory port whose storage can only be written one whole word at a time, because the memory has no per-byte write mask. Reads and whole-word writes go straight through with no added cycles. A write that enables only some byte lanes is carried out as an indivisible pair of memory operations. First the containing word is fetched. The enabled lanes of the new data are then merged into it, and the merged word is written back.

Both ports use a hold-until-acknowledged handshake. The processor raises `req_valid` and holds every request field until `req_ready` is high at a clock edge. The bridge raises `mem_req` and holds its fields until `mem_ack` is high at a clock edge. Each port moves one transfer per acknowledged edge. Every memory address is word-aligned. For a merged write, the processor is acknowledged only when the write-back is acknowledged. A write with no lanes enabled is acknowledged at once and never reaches memory.

Top module: `subword_rmw_bridge`

## Requirements
- R1: A write with every bit of `req_be` set becomes exactly one memory write carrying `req_wdata` unchanged, with no memory read.
- R2: A write that has some but not all bits of `req_be` set becomes exactly one memory read followed by exactly one memory write, both to the same word. `req_ready` rises only in the cycle the write-back receives `mem_ack`.
- R3: In the write-back of R2, byte lane i (bits 8i+7 down to 8i, selected by `req_be[i]`) carries the new write data when `req_be[i]` is 1. When `req_be[i]` is 0, the lane carries the word returned by the read.
- R4: A write with `req_be` all zero gets `req_ready` in the same cycle it is presented and produces no memory request.
- R5: A read becomes exactly one memory read. `rsp_rdata` returns the full word from memory, and `req_ready` equals `mem_ack` while the read is outstanding.
- R6: Every memory request carries the request address with its low log2(DW/8) bits cleared, so the low two bits are zero for the default 32-bit width.
- R7: A pending memory request keeps its address and direction until acknowledged. The processor request is not acknowledged between the read and the write of R2, so no other request can be accepted in between.
- R8: While no processor request is valid, neither `mem_req` nor `req_ready` is asserted. This includes the state right after reset.
- R9: Reads and whole-word writes add no cycles. `req_ready` rises in the same cycle as `mem_ack`, and a read-modify-write takes the two memory latencies plus one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present, held until `req_ready` |
| req_ready | output | 1 | Processor request completes at this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane enables, bit i selects bits 8i+7:8i |
| rsp_rdata | output | DW | Read data, valid when `req_ready` is high for a read |
| mem_req | output | 1 | Memory operation requested, held until `mem_ack` |
| mem_ack | input | 1 | Memory operation completes at this edge |
| mem_we | output | 1 | 1 for a word write, 0 for a word read |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | DW | Whole word to write |
| mem_rdata | input | DW | Word read from memory, valid with `mem_ack` on a read |

## Verification
Two events can fall in the same cycle: the memory's acknowledge of an operation and the processor-side completion. On the direct path and on the write-back of a merge, the two must coincide. On the read phase of a merge, they must not. The memory model can be set to acknowledge with zero wait, which puts the request, the memory acknowledge and the completion all in one cycle. It can also be set to a fixed wait or to a random wait per operation. The bench counts the cycles from request to completion against the expected latency, which is the single latency for direct transfers and twice the latency plus one for merges. It also logs the exact order of memory operations for each request.

// File: rtl/srb_pkg.sv
package srb_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_WBACK = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic none;
      logic full;
      logic part;
   } lane_class_t;

endpackage

// File: rtl/srb_lane_classify.sv
module srb_lane_classify #(
   parameter int NB = 4
) (
   input  logic [NB-1:0]        be,
   output srb_pkg::lane_class_t cls
);
   always_comb begin
      cls.none = ~|be;
      cls.full = &be;
      cls.part = (|be) & ~(&be);
   end
endmodule

// File: rtl/srb_lane_merge.sv
module srb_lane_merge #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]   old_word,
   input  logic [DW-1:0]   new_word,
   input  logic [DW/8-1:0] be,
   output logic [DW-1:0]   merged
);
   localparam int NB = DW / 8;

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign merged[8*g +: 8] = be[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
   end
endmodule

// File: rtl/srb_sequencer.sv
module srb_sequencer #(
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [DW-1:0]        req_wdata,
   input  srb_pkg::lane_class_t cls,
   input  logic [DW-1:0]        merged,
   input  logic                 mem_ack,
   input  logic [DW-1:0]        mem_rdata,
   output logic [DW-1:0]        held_word,
   output logic                 req_ready,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [DW-1:0]        mem_wdata
);
   import srb_pkg::*;

   seq_state_t state, state_nx;
   logic       capture;

   always_comb begin
      state_nx  = state;
      capture   = 1'b0;
      req_ready = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = req_wdata;
      unique case (state)
         SEQ_IDLE: begin
            if (req_valid) begin
               if (!req_write) begin
                  mem_req   = 1'b1;
                  req_ready = mem_ack;
               end else if (cls.none) begin
                  req_ready = 1'b1;
               end else if (cls.full) begin
                  mem_req   = 1'b1;
                  mem_we    = 1'b1;
                  req_ready = mem_ack;
               end else begin
                  mem_req = 1'b1;
                  if (mem_ack) begin
                     capture  = 1'b1;
                     state_nx = SEQ_WBACK;
                  end
               end
            end
         end
         SEQ_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = merged;
            if (mem_ack) begin
               req_ready = 1'b1;
               state_nx  = SEQ_IDLE;
            end
         end
         default: state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         held_word <= '0;
      end else begin
         state <= state_nx;
         if (capture) held_word <= mem_rdata;
      end
   end
endmodule

// File: rtl/subword_rmw_bridge.sv
module subword_rmw_bridge #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic [DW/8-1:0] req_be,
   output logic [DW-1:0]   rsp_rdata,
   output logic            mem_req,
   input  logic            mem_ack,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata
);
   localparam int NB  = DW / 8;
   localparam int OFS = $clog2(NB);

   if (DW % 8 != 0 || DW < 16 || (NB & (NB - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power-of-two number of bytes, at least 16 bits");
   end
   if (AW <= OFS) begin : g_bad_aw
      $error("AW must exceed the byte-offset width");
   end

   srb_pkg::lane_class_t cls;
   logic [DW-1:0]        held_word;
   logic [DW-1:0]        merged;

   srb_lane_classify #(.NB(NB)) u_cls (
      .be  (req_be),
      .cls (cls)
   );

   srb_lane_merge #(.DW(DW)) u_merge (
      .old_word (held_word),
      .new_word (req_wdata),
      .be       (req_be),
      .merged   (merged)
   );

   srb_sequencer #(.DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .cls       (cls),
      .merged    (merged),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .held_word (held_word),
      .req_ready (req_ready),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata)
   );

   assign mem_addr  = {req_addr[AW-1:OFS], {OFS{1'b0}}};
   assign rsp_rdata = mem_rdata;
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            req_write,
   input logic [AW-1:0]   req_addr,
   input logic [DW-1:0]   req_wdata,
   input logic [DW/8-1:0] req_be,
   input logic [DW-1:0]   rsp_rdata,
   input logic            mem_req,
   input logic            mem_ack,
   input logic            mem_we,
   input logic [AW-1:0]   mem_addr,
   input logic [DW-1:0]   mem_wdata,
   input logic [DW-1:0]   mem_rdata
);
   localparam int NB  = DW / 8;
   localparam int OFS = $clog2(NB);

   function automatic logic [DW-1:0] lane_bits(input logic [NB-1:0] b);
      logic [DW-1:0] m;
      for (int i = 0; i < NB; i++) m[8*i +: 8] = {8{b[i]}};
      return m;
   endfunction

   logic wr_full, wr_part;
   assign wr_full = req_valid && req_write && (&req_be);
   assign wr_part = req_valid && req_write && (|req_be) && !(&req_be);

   assert_direct_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full && mem_req |-> mem_we && mem_wdata == req_wdata);

   assert_ack_on_wback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_part && req_ready |-> mem_req && mem_we && mem_ack);

   assert_new_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_part && mem_req && mem_we |-> ((mem_wdata ^ req_wdata) & lane_bits(req_be)) == '0);

   assert_empty_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_be == '0 |-> req_ready && !mem_req);

   assert_read_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && mem_req |->
         !mem_we && req_ready == mem_ack && (!mem_ack || rsp_rdata == mem_rdata));

   assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[OFS-1:0] == '0 && mem_addr[AW-1:OFS] == req_addr[AW-1:OFS]);

   assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_no_ack_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_part && mem_req && !mem_we |-> !req_ready);

   assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !mem_req && !req_ready);

   assert_zero_added_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (wr_full || !req_write) && mem_ack |-> req_ready);
endmodule

bind subword_rmw_bridge srb_checker #(.AW(AW), .DW(DW)) u_srb_checker (.*);

// File: tb/subword_rmw_bridge_bench.sv
`timescale 1ns/1ps
module subword_rmw_bridge_bench;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [3:0]    req_be = '0;
   logic [DW-1:0] rsp_rdata;
   logic          mem_req;
   logic          mem_ack;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;

   always #2 clk = ~clk;

   subword_rmw_bridge #(.AW(AW), .DW(DW)) u_subword_rmw_bridge (.*);

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // memory model: word storage, selectable wait, operation log
   logic [DW-1:0] mem [NW];
   logic [7:0]    ref_bytes [NW*4];
   int            lat_cfg = 0;
   bit            rnd_lat = 1'b0;
   int            wait_cnt = 0;
   int            cur_lat = 0;
   int            ops[$];

   assign mem_ack   = mem_req && (wait_cnt == cur_lat);
   assign mem_rdata = (mem_ack && !mem_we) ? mem[mem_addr[7:2]] : 32'hDEAD_BEEF;

   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
         ops.push_back(mem_we ? 1 : 0);
      end
      if (!mem_req || mem_ack) begin
         wait_cnt <= 0;
         cur_lat  <= rnd_lat ? int'($urandom_range(0, 3)) : lat_cfg;
      end else begin
         wait_cnt <= wait_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of address alignment against the request
   always @(negedge clk) begin
      if (rst_n && mem_req)
         check(mem_addr == {req_addr[AW-1:2], 2'b00}, "R6 aligned address", 64'(mem_addr),
               64'({req_addr[AW-1:2], 2'b00}));
   end

   function automatic logic [31:0] ref_word(input int w);
      return {ref_bytes[4*w+3], ref_bytes[4*w+2], ref_bytes[4*w+1], ref_bytes[4*w]};
   endfunction

   task automatic txn(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                      input logic [3:0] be, input bit timed);
      int cyc = 0;
      int q0;
      int exp_ops[$];
      int exp_cyc;
      logic [31:0] got;
      logic [31:0] expw;
      int w = int'(addr[7:2]);
      string tag;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
      q0 = ops.size();
      #1;
      while (!req_ready && cyc < 60) begin
         @(negedge clk); #1; cyc++;
      end
      got = rsp_rdata;
      @(negedge clk);
      req_valid = 1'b0;
      expw = ref_word(w);
      if (!wr)                 begin tag = "R5 read";        exp_ops = '{0};    exp_cyc = lat_cfg; end
      else if (be == 4'h0)     begin tag = "R4 empty write"; exp_ops = '{};     exp_cyc = 0; end
      else if (be == 4'hF)     begin tag = "R1 full write";  exp_ops = '{1};    exp_cyc = lat_cfg; end
      else                     begin tag = "R2 merge write"; exp_ops = '{0, 1}; exp_cyc = 2*lat_cfg + 1; end
      check(cyc < 60, {tag, " completion"}, 64'(cyc), 64'(exp_cyc));
      check(ops.size() - q0 == exp_ops.size(), {tag, " op count"}, 64'(ops.size() - q0),
            64'(exp_ops.size()));
      for (int k = 0; k < exp_ops.size() && q0 + k < ops.size(); k++)
         check(ops[q0+k] == exp_ops[k], {tag, " op order"}, 64'(ops[q0+k]), 64'(exp_ops[k]));
      if (timed)
         check(cyc == exp_cyc, (be != 4'hF && be != 4'h0 && wr) ? "R7 R9 merge latency" : "R9 latency",
               64'(cyc), 64'(exp_cyc));
      if (!wr) check(got == expw, "R5 read data", 64'(got), 64'(expw));
      else
         for (int b = 0; b < 4; b++)
            if (be[b]) ref_bytes[4*w+b] = wd[8*b +: 8];
   endtask

   task automatic compare_all(input string tag);
      for (int w = 0; w < NW; w++)
         check(mem[w] == ref_word(w), tag, 64'(mem[w]), 64'(ref_word(w)));
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin
         mem[w] = $urandom;
         for (int b = 0; b < 4; b++) ref_bytes[4*w+b] = mem[w][8*b +: 8];
      end
      repeat (3) @(negedge clk);
      check(!mem_req && !req_ready, "R8 reset quiet", {62'd0, mem_req, req_ready}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_req && !req_ready, "R8 idle quiet", {62'd0, mem_req, req_ready}, 64'd0);

      for (int l = 0; l <= 2; l += 2) begin
         lat_cfg = l;
         @(negedge clk);
         txn(1, 32'h10, 32'hA1B2C3D4, 4'hF, 1);         // R1
         txn(0, 32'h10, 32'h0,        4'h0, 1);         // R5
         for (int b = 0; b < 4; b++)
            txn(1, 32'h20 + b, 32'h11223344 << (8*b), 4'h1 << b, 1);   // R3 single lanes
         txn(1, 32'h32, 32'hBEEF0000, 4'hC, 1);         // R3 upper half
         txn(1, 32'h30, 32'h0000CAFE, 4'h3, 1);         // R3 lower half
         txn(1, 32'h44, 32'hFFFFFFFF, 4'h0, 1);         // R4
         txn(1, 32'h45, 32'h5A5A5A5A, 4'h6, 1);         // R3 middle lanes, unaligned address R6
         txn(0, 32'h23, 32'h0,        4'h0, 1);         // R5 after merges
      end
      compare_all("R3 memory after directed");

      rnd_lat = 1'b1;
      for (int i = 0; i < 300; i++) begin
         logic [3:0] be;
         int kind = int'($urandom_range(0, 3));
         be = (kind == 0) ? 4'hF : (kind == 1) ? (($urandom_range(0, 1) != 0) ? 4'h3 : 4'hC)
            : (kind == 2) ? (4'h1 << $urandom_range(0, 3)) : 4'($urandom);
         txn($urandom_range(0, 3) != 0, 32'($urandom_range(0, 255)), $urandom, be, 0);
      end
      compare_all("R3 memory after random mix");

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule